// File: doc/BRIEF.md
# General-Purpose Event Status and Enable Bank

This block keeps two event registers, each 16 bits wide: a status register that records pending events and an enable register that decides which of them may raise an interrupt. Software reaches them one byte at a time over a small request/response port. A hardware strobe from the hot-plug controller marks a pending event, and the block drives a level interrupt request toward the system control interrupt logic.

Requests use valid/ready. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. Writes produce no response. A read returns its byte on `rsp_rdata` with `rsp_valid` one cycle after acceptance. The response stays valid and stable until `rsp_ready` is seen high. While a response is waiting and `rsp_ready` is low, `req_ready` is low and no new request is taken.

The address selects a byte. Within each register, an even offset holds bits 7:0 and an odd offset holds bits 15:8. The status register clears bits written as 1 (write-one-to-clear). The enable register takes the written byte as it is.

Top module: `gpe_event_bank`

## Requirements
- R1: After reset, both registers read 0, `irq` is low, `rsp_valid` is low and `req_ready` is high.
- R2: A read at offset 0 returns status bits 7:0 and offset 1 returns status bits 15:8. Offset 2 returns enable bits 7:0 and offset 3 returns enable bits 15:8. Each read response arrives one cycle after acceptance.
- R3: A write to offset 0 or 1 clears every status bit of that byte written as 1. It leaves the bits written as 0 unchanged, and it leaves the other status byte unchanged.
- R4: A write to offset 2 or 3 replaces that enable byte with the written data and leaves the other enable byte unchanged.
- R5: `irq` is high exactly when status bit 1 and enable bit 1 are both set. No other bit affects it.
- R6: A one-cycle pulse on `hotplug_evt` sets status bit 1 on that clock edge.
- R7: If `hotplug_evt` is high in the same cycle as a status write that would clear bit 1, status bit 1 ends up set.
- R8: Offsets 4 to 7 are unmapped: reads there return 0, and writes there change neither register.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, `rsp_valid` stays high and `rsp_rdata` holds its value. A request offered in that time is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Byte offset |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_rdata | output | 8 | Read data byte |
| hotplug_evt | input | 1 | Hot-plug event strobe, sets status bit 1 |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest case to reach from the ports is a hot-plug strobe that lands on the same clock edge as a write clearing status bit 1. The two inputs come from unrelated sources, so they rarely line up by chance. The bench drives the strobe and the clearing write in the same cycle on purpose, then reads status back to confirm the set won. Response back-pressure is tested in a second task: `rsp_ready` is held low while a conflicting write is offered. The bench then checks that the held byte stays stable and that the enable register was not touched.

// File: rtl/gpe_bank_pkg.sv
package gpe_bank_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STS  = 2'd1,
    SEL_EN   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpe_addr_decode.sv
module gpe_addr_decode #(
  parameter int ADDR_W    = 3,
  parameter int REG_BYTES = 2,
  localparam int BIDX_W   = $clog2(REG_BYTES)
) (
  input  logic [ADDR_W-1:0]           addr,
  output gpe_bank_pkg::reg_sel_e      sel,
  output logic [BIDX_W-1:0]           byte_idx
);
  import gpe_bank_pkg::*;

  always_comb begin
    if (addr < ADDR_W'(REG_BYTES))          sel = SEL_STS;
    else if (addr < ADDR_W'(2 * REG_BYTES)) sel = SEL_EN;
    else                                    sel = SEL_NONE;
    byte_idx = addr[BIDX_W-1:0];
  end
endmodule

// File: rtl/gpe_w1c_reg.sv
module gpe_w1c_reg #(
  parameter int REG_BYTES = 2,
  localparam int BIDX_W   = $clog2(REG_BYTES),
  localparam int REG_W    = REG_BYTES * gpe_bank_pkg::BYTE_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [BIDX_W-1:0]                wr_byte,
  input  logic [gpe_bank_pkg::BYTE_W-1:0]  wr_data,
  input  logic [REG_W-1:0]                 set_vec,
  output logic [REG_W-1:0]                 q
);
  localparam int BW = gpe_bank_pkg::BYTE_W;

  for (genvar b = 0; b < REG_BYTES; b++) begin : g_byte
    logic [BW-1:0] clr_mask;
    logic [BW-1:0] set_part;
    assign clr_mask = (wr_en && wr_byte == BIDX_W'(b)) ? wr_data : '0;
    assign set_part = set_vec[b*BW +: BW];

    always_ff @(posedge clk) begin
      if (!rst_n) q[b*BW +: BW] <= '0;
      else        q[b*BW +: BW] <= (q[b*BW +: BW] & ~clr_mask) | set_part;
    end
  end
endmodule

// File: rtl/gpe_rw_reg.sv
module gpe_rw_reg #(
  parameter int REG_BYTES = 2,
  localparam int BIDX_W   = $clog2(REG_BYTES),
  localparam int REG_W    = REG_BYTES * gpe_bank_pkg::BYTE_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [BIDX_W-1:0]                wr_byte,
  input  logic [gpe_bank_pkg::BYTE_W-1:0]  wr_data,
  output logic [REG_W-1:0]                 q
);
  localparam int BW = gpe_bank_pkg::BYTE_W;

  for (genvar b = 0; b < REG_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        q[b*BW +: BW] <= '0;
      else if (wr_en && wr_byte == BIDX_W'(b))
        q[b*BW +: BW] <= wr_data;
    end
  end
endmodule

// File: rtl/gpe_rsp_stage.sv
module gpe_rsp_stage #(
  localparam int BW = gpe_bank_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] load_data,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [BW-1:0] rsp_rdata,
  output logic          can_accept
);
  assign can_accept = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpe_event_bank.sv
module gpe_event_bank #(
  parameter int ADDR_W      = 3,
  parameter int REG_BYTES   = 2,
  parameter int HOTPLUG_BIT = 1,
  localparam int BW         = gpe_bank_pkg::BYTE_W,
  localparam int REG_W      = REG_BYTES * BW,
  localparam int BIDX_W     = $clog2(REG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BW-1:0]     rsp_rdata,
  input  logic              hotplug_evt,
  output logic              irq
);
  import gpe_bank_pkg::*;

  reg_sel_e          sel;
  logic [BIDX_W-1:0] byte_idx;
  logic              accept;
  logic              wr_sts, wr_en_reg, rd_acc;
  logic [REG_W-1:0]  status_q, enable_q, set_vec;
  logic [BW-1:0]     rd_byte;

  gpe_addr_decode #(.ADDR_W(ADDR_W), .REG_BYTES(REG_BYTES)) u_dec (
    .addr(req_addr), .sel(sel), .byte_idx(byte_idx)
  );

  assign accept    = req_valid && req_ready;
  assign wr_sts    = accept && req_write && sel == SEL_STS;
  assign wr_en_reg = accept && req_write && sel == SEL_EN;
  assign rd_acc    = accept && !req_write;
  assign set_vec   = REG_W'(hotplug_evt) << HOTPLUG_BIT;

  gpe_w1c_reg #(.REG_BYTES(REG_BYTES)) u_sts (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_sts), .wr_byte(byte_idx),
    .wr_data(req_wdata), .set_vec(set_vec), .q(status_q)
  );

  gpe_rw_reg #(.REG_BYTES(REG_BYTES)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_reg), .wr_byte(byte_idx),
    .wr_data(req_wdata), .q(enable_q)
  );

  always_comb begin
    unique case (sel)
      SEL_STS: rd_byte = status_q[byte_idx*BW +: BW];
      SEL_EN:  rd_byte = enable_q[byte_idx*BW +: BW];
      default: rd_byte = '0;
    endcase
  end

  gpe_rsp_stage u_rsp (
    .clk(clk), .rst_n(rst_n), .load(rd_acc), .load_data(rd_byte),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .can_accept(req_ready)
  );

  assign irq = status_q[HOTPLUG_BIT] & enable_q[HOTPLUG_BIT];
endmodule

// File: rtl/gpe_event_bank_chk.sv
module gpe_event_bank_chk #(
  parameter int ADDR_W      = 3,
  parameter int REG_BYTES   = 2,
  parameter int HOTPLUG_BIT = 1,
  parameter int REG_W       = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [7:0]        rsp_rdata,
  input logic              hotplug_evt,
  input logic              irq,
  input logic [REG_W-1:0]  status_q,
  input logic [REG_W-1:0]  enable_q
);
  logic acc_wr;
  assign acc_wr = req_valid && req_ready && req_write;

  assert_hotplug_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hotplug_evt |=> status_q[HOTPLUG_BIT]);

  // R7: the set also wins over a concurrent clearing write
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hotplug_evt && acc_wr && req_addr == '0) |=> status_q[HOTPLUG_BIT]);

  assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hotplug_evt && enable_q[HOTPLUG_BIT] && !acc_wr) |=> irq);

  assert_en_low_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && req_addr == ADDR_W'(REG_BYTES)) |=> enable_q[7:0] == $past(req_wdata));

  assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && req_addr >= ADDR_W'(2 * REG_BYTES)) |=> enable_q == $past(enable_q));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind gpe_event_bank gpe_event_bank_chk #(
  .ADDR_W(ADDR_W), .REG_BYTES(REG_BYTES), .HOTPLUG_BIT(HOTPLUG_BIT), .REG_W(REG_W)
) chk_i (.*);

// File: tb/gpe_event_bank_tb_top.sv
module gpe_event_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_ready = 1'b1, hotplug_evt = 1'b0;
  logic       req_ready, rsp_valid, irq;
  logic [7:0] rsp_rdata;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpe_event_bank dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .hotplug_evt(hotplug_evt), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit evt = 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; hotplug_evt = evt;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; hotplug_evt = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " rdata"}, 32'(rsp_rdata), 32'(exp));
  endtask

  task automatic pulse_hotplug();
    @(negedge clk); hotplug_evt = 1'b1;
    @(negedge clk); hotplug_evt = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 req_ready", 32'(req_ready), 32'd1);
    for (int i = 0; i < 4; i++) rd(3'(i), 8'h00, "R1 reg");
  endtask

  task automatic t_enable();
    wr(3'd2, 8'hA5);
    wr(3'd3, 8'h3C);
    rd(3'd2, 8'hA5, "R4/R2 en lo");
    rd(3'd3, 8'h3C, "R4/R2 en hi");
    wr(3'd3, 8'h5A);
    rd(3'd2, 8'hA5, "R4 other byte kept");
    rd(3'd3, 8'h5A, "R4 hi replaced");
  endtask

  task automatic t_status_irq();
    pulse_hotplug();
    rd(3'd0, 8'h02, "R6 status set");
    rd(3'd1, 8'h00, "R2 status hi");
    check("R5 irq masked", 32'(irq), 32'd0);
    wr(3'd2, 8'h02);
    check("R5 irq on", 32'(irq), 32'd1);
    wr(3'd0, 8'hFD);
    rd(3'd0, 8'h02, "R3 zero bit kept");
    wr(3'd1, 8'hFF);
    rd(3'd0, 8'h02, "R3 other byte kept");
    check("R5 irq still on", 32'(irq), 32'd1);
    wr(3'd2, 8'hFD);
    check("R5 other enables ignored", 32'(irq), 32'd0);
    wr(3'd2, 8'h02);
    wr(3'd0, 8'h02);
    rd(3'd0, 8'h00, "R3 cleared");
    check("R5 irq off", 32'(irq), 32'd0);
  endtask

  task automatic t_collision();
    wr(3'd0, 8'h02, 1'b1);
    rd(3'd0, 8'h02, "R7 set wins");
    check("R7 irq", 32'(irq), 32'd1);
  endtask

  task automatic t_unmapped();
    rd(3'd5, 8'h00, "R8 read unmapped");
    rd(3'd7, 8'h00, "R8 read unmapped");
    wr(3'd6, 8'hFF);
    wr(3'd4, 8'hFF);
    rd(3'd2, 8'h02, "R8 en lo untouched");
    rd(3'd3, 8'h5A, "R8 en hi untouched");
    rd(3'd0, 8'h02, "R8 status untouched");
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd3;
    @(negedge clk);
    req_write = 1'b1; req_addr = 3'd3; req_wdata = 8'h00;
    check("R9 rsp_valid", 32'(rsp_valid), 32'd1);
    check("R9 req_ready low", 32'(req_ready), 32'd0);
    check("R9 rdata", 32'(rsp_rdata), 32'h5A);
    @(negedge clk);
    check("R9 held valid", 32'(rsp_valid), 32'd1);
    check("R9 held rdata", 32'(rsp_rdata), 32'h5A);
    req_valid = 1'b0; req_write = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 drained", 32'(rsp_valid), 32'd0);
    rd(3'd3, 8'h5A, "R9 stalled write not taken");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_status_irq();
    t_collision();
    t_unmapped();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule